// File: doc/BRIEF.md
# Interrupt Register Bank Controller

This block keeps a stack of register banks so that a processor can park its working registers on interrupt entry without any memory traffic. A bank is one frame of twenty 32-bit slots: fifteen general registers, the global base, both halves of the multiply accumulator, the procedure return register and the interrupt vector table offset. Frames are pushed and popped in last-in first-out order under a bank counter that software can read but never write.

A save request copies the frame from the register file one slot per cycle into the bank the counter names, then advances the counter. A restore request first steps the counter back and then streams that bank out one slot per cycle. Once every bank holds a frame, a further save either raises an overflow error or, when overflow errors are off, asks for the frame to go to the memory stack and sets a sticky overflow flag. Spilled frames come back first: such a restore runs for 19 cycles and asks for the stack read. A direct port reads and writes any slot, for the instructions that move single registers to and from a bank.

Top module: `irb_ctrl`

## Requirements
- R1: After reset, bank_num is 0, ovf_flag is 0, busy is 0 and no pulse output (ovf_err, udf_err, spill_req, unspill_req) nor rs_valid is high.
- R2: A save accepted while bank_num is below NUM_BANKS keeps busy high for 20 cycles, with sv_idx counting 0 to 19; sv_data sampled with sv_idx = k is stored in slot k of bank bank_num, and bank_num then rises by one when busy falls.
- R3: A bank restore lowers bank_num by one in the cycle after acceptance, then for 20 cycles holds rs_valid high with rs_idx counting 0 to 19 and rs_data giving that slot of the newly selected bank; the last frame saved is the first restored.
- R4: A restore with bank_num at 0 and no frame on the memory stack gives a one-cycle udf_err pulse, does not assert busy and leaves bank_num at 0.
- R5: A save with bank_num at NUM_BANKS and ovf_exc_en = 1 gives a one-cycle ovf_err pulse, stores nothing and leaves bank_num unchanged.
- R6: A save with bank_num at NUM_BANKS and ovf_exc_en = 0 gives a one-cycle spill_req pulse and sets ovf_flag, which stays set while frames remain spilled.
- R7: While spilled frames remain, a restore gives a one-cycle unspill_req pulse, keeps busy high for 19 cycles and leaves bank_num unchanged; once every spilled frame is back, restores read the banks again.
- R8: ovf_flag clears in the same cycle that a bank restore brings bank_num down from NUM_BANKS.
- R9: On the direct port, dp_addr bits 6 to 2 pick the slot and the bits above bit 6 pick the bank; a read returns the slot on dp_rdata one cycle after dp_en, and an address naming a slot above 19 or a bank at or beyond NUM_BANKS reads as 0 and ignores writes.
- R10: A save or restore request that arrives while busy is held and started after the current operation ends, the held save going first when both are held.
- R11: A direct-port write issued while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Interrupt accepted, frame must be saved |
| restore_req | input | 1 | Restore instruction issued |
| ovf_exc_en | input | 1 | 1: full stack raises an error; 0: frame spills to memory |
| sv_data | input | DATA_W | Register file value for slot sv_idx |
| sv_idx | output | 5 | Slot being saved |
| rs_valid | output | 1 | rs_data carries a restored slot |
| rs_idx | output | 5 | Slot being restored |
| rs_data | output | DATA_W | Restored value |
| dp_en | input | 1 | Direct port access strobe |
| dp_we | input | 1 | Direct port write when 1, read when 0 |
| dp_addr | input | ADDR_W-2 | Word address, bits ADDR_W-1 down to 2 |
| dp_wdata | input | DATA_W | Direct port write data |
| dp_rdata | output | DATA_W | Direct port read data, one cycle after the read |
| busy | output | 1 | Save, restore or stack restore in progress |
| bank_num | output | BN_W | Number of banks holding a frame |
| ovf_flag | output | 1 | Sticky flag: frames went to the memory stack |
| ovf_err | output | 1 | Bank overflow error pulse |
| udf_err | output | 1 | Bank underflow error pulse |
| spill_req | output | 1 | Pulse asking for a frame to be pushed to memory |
| unspill_req | output | 1 | Pulse asking for a frame to be read back from memory |

## Verification
Every request is taken at the clock edge after it is driven, so busy, the first sv_idx or rs_idx, the new bank_num after a restore and all error and spill pulses show up one cycle after the request; the raised bank_num after a save appears 21 cycles after the request, and busy after a stack restore falls 20 cycles after it. Direct-port read data is due one cycle after the strobe. The bench drives inputs on the falling edge and compares at the following falling edges cycle by cycle against a reference model of bank contents, bank count, spilled-frame count and flag, so every result is sampled exactly in the cycle it is due. Held requests are checked by watching the one idle cycle between back-to-back operations and which operation follows it.

// File: rtl/irb_ctrl.sv
module irb_ctrl #(
  parameter int NUM_BANKS = 15,
  parameter int DATA_W    = 32,
  parameter int SPILL_W   = 8,
  localparam int BN_W     = $clog2(NUM_BANKS + 1),
  localparam int ADDR_W   = 7 + BN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic              ovf_exc_en,
  input  logic [DATA_W-1:0] sv_data,
  output logic [4:0]        sv_idx,
  output logic              rs_valid,
  output logic [4:0]        rs_idx,
  output logic [DATA_W-1:0] rs_data,
  input  logic              dp_en,
  input  logic              dp_we,
  input  logic [ADDR_W-1:2] dp_addr,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic [DATA_W-1:0] dp_rdata,
  output logic              busy,
  output logic [BN_W-1:0]   bank_num,
  output logic              ovf_flag,
  output logic              ovf_err,
  output logic              udf_err,
  output logic              spill_req,
  output logic              unspill_req
);

  localparam int ENTRIES   = 20;
  localparam int STACK_CYC = 19;
  localparam int IDX_W     = 5;
  localparam int DEPTH     = NUM_BANKS * ENTRIES;
  localparam int AW        = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_ENT = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LAST_STK = IDX_W'(STACK_CYC - 1);
  localparam logic [BN_W-1:0]  BN_FULL  = BN_W'(NUM_BANKS);

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD, ST_UNSPILL} state_t;

  state_t             st;
  logic [IDX_W-1:0]   cnt;
  logic [BN_W-1:0]    bn;
  logic               bo;
  logic [SPILL_W-1:0] spills;
  logic               pend_s, pend_r;
  logic [DATA_W-1:0]  mem [DEPTH];

  function automatic logic [AW-1:0] slot(input logic [BN_W-1:0] b, input logic [IDX_W-1:0] e);
    return AW'(b) * AW'(ENTRIES) + AW'(e);
  endfunction

  wire idle   = (st == ST_IDLE);
  wire want_s = save_req | pend_s;
  wire want_r = restore_req | pend_r;
  wire done   = (st == ST_UNSPILL) ? (cnt == LAST_STK) : (cnt == LAST_ENT);

  wire [IDX_W-1:0] dp_ent  = dp_addr[6:2];
  wire [BN_W-1:0]  dp_bank = dp_addr[ADDR_W-1:7];
  wire             dp_ok   = (dp_ent <= LAST_ENT) && (dp_bank < BN_FULL);

  assign busy     = ~idle;
  assign bank_num = bn;
  assign ovf_flag = bo;
  assign sv_idx   = cnt;
  assign rs_idx   = cnt;
  assign rs_valid = (st == ST_LOAD);
  assign rs_data  = rs_valid ? mem[slot(bn, cnt)] : '0;

  always_ff @(posedge clk) begin
    if (st == ST_SAVE)
      mem[slot(bn, cnt)] <= sv_data;
    else if (idle && dp_en && dp_we && dp_ok)
      mem[slot(dp_bank, dp_ent)] <= dp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dp_rdata <= '0;
    else if (dp_en && !dp_we)
      dp_rdata <= dp_ok ? mem[slot(dp_bank, dp_ent)] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      bn          <= '0;
      bo          <= 1'b0;
      spills      <= '0;
      pend_s      <= 1'b0;
      pend_r      <= 1'b0;
      ovf_err     <= 1'b0;
      udf_err     <= 1'b0;
      spill_req   <= 1'b0;
      unspill_req <= 1'b0;
    end else begin
      ovf_err     <= 1'b0;
      udf_err     <= 1'b0;
      spill_req   <= 1'b0;
      unspill_req <= 1'b0;
      if (idle) begin
        cnt    <= '0;
        pend_s <= 1'b0;
        pend_r <= want_s & want_r;
        if (want_s) begin
          if (bn != BN_FULL) begin
            st <= ST_SAVE;
          end else if (ovf_exc_en) begin
            ovf_err <= 1'b1;
          end else begin
            spill_req <= 1'b1;
            bo        <= 1'b1;
            if (spills != '1) spills <= spills + 1'b1;
          end
        end else if (want_r) begin
          if (spills != '0) begin
            st          <= ST_UNSPILL;
            unspill_req <= 1'b1;
          end else if (bn == '0) begin
            udf_err <= 1'b1;
          end else begin
            bn <= bn - 1'b1;
            bo <= 1'b0;
            st <= ST_LOAD;
          end
        end
      end else begin
        if (save_req)    pend_s <= 1'b1;
        if (restore_req) pend_r <= 1'b1;
        cnt <= cnt + 1'b1;
        if (done) begin
          st <= ST_IDLE;
          if (st == ST_SAVE)    bn     <= bn + 1'b1;
          if (st == ST_UNSPILL) spills <= spills - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irb_ctrl_chk.sv
module irb_ctrl_chk #(
  parameter int NUM_BANKS = 15,
  localparam int BN_W     = $clog2(NUM_BANKS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rs_valid,
  input logic [4:0]      rs_idx,
  input logic [BN_W-1:0] bank_num,
  input logic            ovf_flag,
  input logic            ovf_err,
  input logic            udf_err,
  input logic            spill_req,
  input logic            unspill_req
);
  localparam logic [BN_W-1:0] BN_FULL = BN_W'(NUM_BANKS);

  a_r2_bank_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bank_num <= BN_FULL);

  a_r2_bank_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_num != $past(bank_num)) |->
      ((bank_num == $past(bank_num) + 1'b1) || (bank_num == $past(bank_num) - 1'b1)));

  a_r3_rs_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && $past(rs_valid)) |-> (rs_idx == $past(rs_idx) + 1'b1));

  a_r4_udf_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    udf_err |-> (bank_num == '0 && !busy));

  a_r5_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (bank_num == BN_FULL && !busy));

  a_r6_spill_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |-> (ovf_flag && bank_num == BN_FULL));

  a_r7_unspill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    unspill_req |-> (busy && !rs_valid));

  a_r8_flag_clears_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> (rs_valid && bank_num == BN_FULL - 1'b1));

  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_err, udf_err, spill_req, unspill_req}));
endmodule

bind irb_ctrl irb_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rs_valid(rs_valid), .rs_idx(rs_idx),
  .bank_num(bank_num), .ovf_flag(ovf_flag), .ovf_err(ovf_err), .udf_err(udf_err),
  .spill_req(spill_req), .unspill_req(unspill_req)
);

// File: tb/test_irb_ctrl.sv
module test_irb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 15;
  localparam int NE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        save_req = 1'b0, restore_req = 1'b0, ovf_exc_en = 1'b0;
  logic [31:0] sv_data;
  logic [4:0]  sv_idx;
  logic        rs_valid;
  logic [4:0]  rs_idx;
  logic [31:0] rs_data;
  logic        dp_en = 1'b0, dp_we = 1'b0;
  logic [10:2] dp_addr = '0;
  logic [31:0] dp_wdata = '0;
  logic [31:0] dp_rdata;
  logic        busy;
  logic [3:0]  bank_num;
  logic        ovf_flag, ovf_err, udf_err, spill_req, unspill_req;

  logic [31:0] tag = 32'h1;
  logic [31:0] exp_mem [NB*NE];
  int          m_bn = 0, m_spill = 0;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] t, input logic [4:0] k);
    return t * 32'h9E37_79B1 + {27'd0, k};
  endfunction

  assign sv_data = pat(tag, sv_idx);

  irb_ctrl i_irb_ctrl (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .ovf_exc_en(ovf_exc_en), .sv_data(sv_data), .sv_idx(sv_idx), .rs_valid(rs_valid),
    .rs_idx(rs_idx), .rs_data(rs_data), .dp_en(dp_en), .dp_we(dp_we), .dp_addr(dp_addr),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .busy(busy), .bank_num(bank_num),
    .ovf_flag(ovf_flag), .ovf_err(ovf_err), .udf_err(udf_err), .spill_req(spill_req),
    .unspill_req(unspill_req)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [10:2] mkaddr(input int b, input int e);
    return {b[3:0], e[4:0]};
  endfunction

  function automatic bit in_range(input logic [10:2] a);
    return (int'(a[6:2]) < NE) && (int'(a[10:7]) < NB);
  endfunction

  function automatic int idx_of(input logic [10:2] a);
    return int'(a[10:7]) * NE + int'(a[6:2]);
  endfunction

  task automatic dp_wr(input logic [10:2] a, input logic [31:0] d);
    @(negedge clk);
    dp_en = 1'b1; dp_we = 1'b1; dp_addr = a; dp_wdata = d;
    @(negedge clk);
    dp_en = 1'b0; dp_we = 1'b0;
    if (in_range(a)) exp_mem[idx_of(a)] = d;
  endtask

  task automatic dp_rd(input logic [10:2] a);
    @(negedge clk);
    dp_en = 1'b1; dp_we = 1'b0; dp_addr = a;
    @(negedge clk);
    dp_en = 1'b0;
    chk("R9 dp_rdata", dp_rdata, in_range(a) ? exp_mem[idx_of(a)] : 32'h0);
  endtask

  // Called at the first falling edge after the accepting edge; returns at an idle falling edge.
  task automatic exp_save(input bit en, input bit inject);
    if (m_bn < NB) begin
      for (int k = 0; k < NE; k++) begin
        chk("R2 busy", {31'd0, busy}, 32'd1);
        chk("R2 sv_idx", {27'd0, sv_idx}, k);
        chk("R2 bank_num held", {28'd0, bank_num}, m_bn);
        exp_mem[m_bn*NE + k] = pat(tag, 5'(k));
        if (inject && k == 3) begin
          save_req = 1'b1; restore_req = 1'b1;
          dp_en = 1'b1; dp_we = 1'b1; dp_addr = mkaddr(0, 0); dp_wdata = 32'hDEAD_BEEF;
        end
        if (inject && k == 4) begin
          save_req = 1'b0; restore_req = 1'b0; dp_en = 1'b0; dp_we = 1'b0;
        end
        @(negedge clk);
      end
      m_bn++;
      chk("R2 busy end", {31'd0, busy}, 32'd0);
      chk("R2 bank_num inc", {28'd0, bank_num}, m_bn);
    end else if (en) begin
      chk("R5 ovf_err", {31'd0, ovf_err}, 32'd1);
      chk("R5 busy", {31'd0, busy}, 32'd0);
      chk("R5 bank_num", {28'd0, bank_num}, m_bn);
      @(negedge clk);
      chk("R5 ovf_err pulse", {31'd0, ovf_err}, 32'd0);
    end else begin
      m_spill++;
      chk("R6 spill_req", {31'd0, spill_req}, 32'd1);
      chk("R6 ovf_flag", {31'd0, ovf_flag}, 32'd1);
      chk("R6 busy", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk("R6 spill_req pulse", {31'd0, spill_req}, 32'd0);
      chk("R6 ovf_flag sticky", {31'd0, ovf_flag}, 32'd1);
    end
  endtask

  task automatic exp_restore();
    if (m_spill > 0) begin
      for (int k = 0; k < 19; k++) begin
        chk("R7 busy", {31'd0, busy}, 32'd1);
        chk("R7 unspill_req", {31'd0, unspill_req}, (k == 0) ? 32'd1 : 32'd0);
        chk("R7 bank_num held", {28'd0, bank_num}, m_bn);
        chk("R7 ovf_flag", {31'd0, ovf_flag}, 32'd1);
        @(negedge clk);
      end
      m_spill--;
      chk("R7 busy end", {31'd0, busy}, 32'd0);
    end else if (m_bn == 0) begin
      chk("R4 udf_err", {31'd0, udf_err}, 32'd1);
      chk("R4 busy", {31'd0, busy}, 32'd0);
      chk("R4 bank_num", {28'd0, bank_num}, 32'd0);
      @(negedge clk);
      chk("R4 udf_err pulse", {31'd0, udf_err}, 32'd0);
    end else begin
      m_bn--;
      for (int k = 0; k < NE; k++) begin
        chk("R3 rs_valid", {31'd0, rs_valid}, 32'd1);
        chk("R3 rs_idx", {27'd0, rs_idx}, k);
        chk("R3 rs_data", rs_data, exp_mem[m_bn*NE + k]);
        chk("R3 bank_num dec", {28'd0, bank_num}, m_bn);
        chk("R8 ovf_flag cleared", {31'd0, ovf_flag}, 32'd0);
        @(negedge clk);
      end
      chk("R3 end", {30'd0, busy, rs_valid}, 32'd0);
    end
  endtask

  task automatic req_save(input bit en);
    @(negedge clk);
    save_req = 1'b1; ovf_exc_en = en;
    @(negedge clk);
    save_req = 1'b0;
    exp_save(en, 1'b0);
  endtask

  task automatic req_restore();
    @(negedge clk);
    restore_req = 1'b1;
    @(negedge clk);
    restore_req = 1'b0;
    exp_restore();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bank_num", {28'd0, bank_num}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ovf_flag", {31'd0, ovf_flag}, 32'd0);
    chk("R1 pulses", {27'd0, ovf_err, udf_err, spill_req, unspill_req, rs_valid}, 32'd0);

    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++)
        dp_wr(mkaddr(b, e), $urandom);
    dp_rd(mkaddr(0, 0));
    dp_rd(mkaddr(14, 19));
    dp_rd(mkaddr(7, 11));
    dp_wr(mkaddr(0, 20), 32'h1111_2222);
    dp_rd(mkaddr(0, 20));
    dp_wr(mkaddr(15, 3), 32'h3333_4444);
    dp_rd(mkaddr(15, 3));

    req_restore();                         // R4 underflow from empty
    tag = 32'h55;
    req_save(1'b0);
    // R10 and R11: requests and a direct write land while busy
    tag = 32'h66;
    @(negedge clk); save_req = 1'b1; ovf_exc_en = 1'b1;
    @(negedge clk); save_req = 1'b0;
    exp_save(1'b1, 1'b1);
    chk("R10 idle gap", {31'd0, busy}, 32'd0);
    @(negedge clk);
    exp_save(1'b1, 1'b0);                  // held save starts first
    @(negedge clk);
    exp_restore();                         // then held restore
    dp_rd(mkaddr(0, 0));                   // R11 write while busy ignored
    while (m_bn > 0) begin tag = tag + 32'd3; req_restore(); end
    req_restore();

    for (int i = 0; i < NB; i++) begin tag = 32'h100 + i; req_save($urandom % 2 == 1); end
    chk("R2 full", {28'd0, bank_num}, NB);
    req_save(1'b0);
    req_save(1'b0);
    req_save(1'b1);
    req_restore();
    req_restore();
    chk("R7 flag held after stack restores", {31'd0, ovf_flag}, 32'd1);
    req_restore();
    chk("R8 flag clear", {31'd0, ovf_flag}, 32'd0);
    dp_wr(mkaddr(3, 5), 32'hCAFE_0001);
    dp_rd(mkaddr(3, 5));

    for (int i = 0; i < 250; i++) begin
      int unsigned op;
      op = $urandom % 8;
      if (op < 3) begin
        tag = $urandom;
        req_save($urandom % 2 == 1);
      end else if (op < 5) begin
        req_restore();
      end else if (op == 5) begin
        dp_wr(9'($urandom), $urandom);
      end else if (op == 6) begin
        logic [10:2] a;
        a = 9'($urandom);
        if (!in_range(a) || exp_mem[idx_of(a)] !== 32'hx) dp_rd(a);
      end else begin
        repeat (1 + $urandom % 3) @(negedge clk);
        chk("R1 idle busy", {31'd0, busy}, 32'd0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule